// File: doc/BRIEF.md
# Security access fault capture unit

This unit sits beside a memory port and looks at every access request issued by up to 32 bus masters. A request counts as a failure when the region decoder upstream flags it, or when the master is marked non-secure in a per-master configuration word but presents the access as secure. The unit keeps the details of the first such failure. These are the address, the direction, the security and privilege attributes, and the master number. It also raises a sticky interrupt.

The captured address is trimmed to the burst granularity of the attached external memory. A memory-type selector picks how many low address bits read as zero. Software reads the record through a small register port and then writes a clear. The clear drops the interrupt and arms the unit for the next failure. Failures that arrive while the interrupt is pending are dropped, so the record always describes the first one.

Top module: `sec_fault_capture`

## Requirements
- R1: The master security word is at register offset 0x00. It is read/write and resets to 0. Bit n belongs to master n: 0 means secure and 1 means non-secure.
- R2: An access (`acc_valid`=1) fails when `acc_region_fail`=1. It also fails when the master's bit in the security word is 1 and `acc_ns`=0.
- R3: The clock edge that samples a failing access sets `irq`. `irq` then stays at 1 until it is cleared.
- R4: While `irq` is 1 and no clear is written, further failures leave the fail address and fail control registers unchanged.
- R5: The fail address register is at offset 0x20 and resets to 0. It holds the failing address with low bits forced to zero by `mem_type`: 0 (16-bit DDR2) zeroes bits [2:0], 1 (32-bit DDR2) and 2 (16-bit DDR3) zero bits [3:0], and 3 (32-bit DDR3) zeroes bits [4:0].
- R6: The fail control register is at offset 0x28 and resets to 0. It holds: bit 24 = write (1) or read (0), bit 21 = `acc_ns`, bit 20 = `acc_priv`, and bits 19:0 = the master ID zero-extended. All other bits read 0.
- R7: Writing a word with bit 0 = 1 to offset 0x2C clears `irq` on the next edge and arms the next capture. Writing bit 0 = 0 has no effect. Reading 0x2C returns `irq` in bit 0.
- R8: If a clear and a failure occur in the same cycle, the failure is captured and `irq` remains 1.
- R9: An access that does not fail changes neither `irq` nor the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_id | input | 5 | Requesting master number |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ns | input | 1 | Access presented as non-secure |
| acc_priv | input | 1 | Access is privileged |
| acc_region_fail | input | 1 | Region permission check failed |
| mem_type | input | 2 | External memory type/width selector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Sticky fault interrupt |

## Verification
Every stored result comes one clock edge after its stimulus. This covers `irq`, the captured address and control word, the security word and the clear. The bench applies each stimulus at a falling edge and removes it at the next falling edge. It samples at that same falling edge, which is exactly one rising edge later. Register reads are combinational on `reg_addr`. The bench therefore sets the offset and samples after a short settle delay, with no clock edge in between.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int DW      = 32;
  localparam int ID_W    = 5;
  localparam int IDF_W   = 20;
  localparam int BIT_WR  = 24;
  localparam int BIT_NS  = 21;
  localparam int BIT_PRV = 20;

  localparam logic [7:0] OFS_CFG  = 8'h00;
  localparam logic [7:0] OFS_ADDR = 8'h20;
  localparam logic [7:0] OFS_CTRL = 8'h28;
  localparam logic [7:0] OFS_IRQ  = 8'h2C;

  typedef enum logic [1:0] {
    MT_D2_X16 = 2'd0,
    MT_D2_X32 = 2'd1,
    MT_D3_X16 = 2'd2,
    MT_D3_X32 = 2'd3
  } mem_type_e;

  // number of low address bits forced to zero for a memory type
  function automatic int unsigned zero_lsbs(input logic [1:0] mt);
    case (mem_type_e'(mt))
      MT_D2_X16: return 3;
      MT_D3_X32: return 5;
      default:   return 4;
    endcase
  endfunction

  function automatic logic [DW-1:0] trim_addr(input logic [DW-1:0] a,
                                               input logic [1:0] mt);
    logic [DW-1:0] m;
    m = ~((DW'(1) << zero_lsbs(mt)) - DW'(1));
    return a & m;
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input logic wr, input logic ns,
                                               input logic prv,
                                               input logic [ID_W-1:0] id);
    logic [DW-1:0] w;
    w = '0;
    w[IDF_W-1:0] = IDF_W'(id);
    w[BIT_PRV]   = prv;
    w[BIT_NS]    = ns;
    w[BIT_WR]    = wr;
    return w;
  endfunction
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] cap_addr,
  input  logic [DW-1:0] cap_ctrl,
  input  logic          irq,
  output logic [DW-1:0] sec_cfg,
  output logic          clr_req,
  output logic [DW-1:0] reg_rdata
);
  logic cfg_we;
  assign cfg_we  = reg_wr && (reg_addr == OFS_CFG);
  assign clr_req = reg_wr && (reg_addr == OFS_IRQ) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_cfg <= '0;
    else if (cfg_we) sec_cfg <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      OFS_CFG:  reg_rdata = sec_cfg;
      OFS_ADDR: reg_rdata = cap_addr;
      OFS_CTRL: reg_rdata = cap_ctrl;
      OFS_IRQ:  reg_rdata = {{(DW-1){1'b0}}, irq};
      default:  reg_rdata = '0;
    endcase
  end

  // R1: a write to the security word is visible on the next cycle
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> sec_cfg == $past(reg_wdata));
  // R6: reserved control bits never carry data
  p_ctrl_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ctrl[DW-1:BIT_WR+1] == '0) && (cap_ctrl[BIT_WR-1:BIT_NS+1] == '0));
endmodule

// File: rtl/sfc_detect.sv
module sfc_detect
  import sfc_pkg::*;
#(
  parameter int N_MASTERS = 32
) (
  input  logic                 acc_valid,
  input  logic [ID_W-1:0]      acc_id,
  input  logic                 acc_ns,
  input  logic                 acc_region_fail,
  input  logic [N_MASTERS-1:0] sec_cfg,
  output logic                 fail_evt
);
  logic master_ns;
  logic sec_mismatch;

  assign master_ns    = sec_cfg[acc_id];
  assign sec_mismatch = master_ns && !acc_ns;
  assign fail_evt     = acc_valid && (acc_region_fail || sec_mismatch);
endmodule

// File: rtl/sfc_capture.sv
module sfc_capture
  import sfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_evt,
  input  logic          clr_req,
  input  logic [DW-1:0] acc_addr,
  input  logic [1:0]    mem_type,
  input  logic [DW-1:0] ctrl_word,
  output logic          irq,
  output logic [DW-1:0] cap_addr,
  output logic [DW-1:0] cap_ctrl
);
  logic take;
  assign take = fail_evt && (!irq || clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      cap_addr <= '0;
      cap_ctrl <= '0;
    end else begin
      if (take) begin
        irq      <= 1'b1;
        cap_addr <= trim_addr(acc_addr, mem_type);
        cap_ctrl <= ctrl_word;
      end else if (clr_req) begin
        irq <= 1'b0;
      end
    end
  end

  // R3: a failure always leaves the interrupt set
  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> irq);
  // R3: interrupt is sticky without a clear
  p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);
  // R4: record is frozen while pending
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> ($stable(cap_addr) && $stable(cap_ctrl)));
  // R5: captured address has its low bits cleared
  p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((cap_addr & ((DW'(1) << zero_lsbs($past(mem_type))) - DW'(1))) == '0));
  // R7: a lone clear drops the interrupt
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fail_evt) |=> !irq);
  // R9: without a failure the record does not move
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_evt |=> ($stable(cap_addr) && $stable(cap_ctrl)));
endmodule

// File: rtl/sec_fault_capture.sv
module sec_fault_capture
  import sfc_pkg::*;
#(
  parameter int N_MASTERS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [ID_W-1:0] acc_id,
  input  logic [DW-1:0]   acc_addr,
  input  logic            acc_write,
  input  logic            acc_ns,
  input  logic            acc_priv,
  input  logic            acc_region_fail,
  input  logic [1:0]      mem_type,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  logic [DW-1:0] sec_cfg;
  logic          clr_req;
  logic          fail_evt;
  logic [DW-1:0] cap_addr;
  logic [DW-1:0] cap_ctrl;
  logic [DW-1:0] ctrl_word;

  assign ctrl_word = pack_ctrl(acc_write, acc_ns, acc_priv, acc_id);

  sfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cap_addr(cap_addr), .cap_ctrl(cap_ctrl),
    .irq(irq), .sec_cfg(sec_cfg), .clr_req(clr_req), .reg_rdata(reg_rdata)
  );

  sfc_detect #(.N_MASTERS(N_MASTERS)) u_detect (
    .acc_valid(acc_valid), .acc_id(acc_id), .acc_ns(acc_ns),
    .acc_region_fail(acc_region_fail), .sec_cfg(sec_cfg[N_MASTERS-1:0]),
    .fail_evt(fail_evt)
  );

  sfc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .fail_evt(fail_evt), .clr_req(clr_req),
    .acc_addr(acc_addr), .mem_type(mem_type), .ctrl_word(ctrl_word),
    .irq(irq), .cap_addr(cap_addr), .cap_ctrl(cap_ctrl)
  );

  // R8: clear and failure together keep the interrupt up
  p_clr_and_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && fail_evt) |=> (irq && cap_ctrl == $past(ctrl_word)));
endmodule

// File: tb/test_sec_fault_capture.sv
module test_sec_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0, acc_ns = 0, acc_priv = 0, acc_region_fail = 0;
  logic [4:0]  acc_id = '0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  mem_type = '0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sec_fault_capture i_sec_fault_capture (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_id(acc_id),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_ns(acc_ns),
    .acc_priv(acc_priv), .acc_region_fail(acc_region_fail), .mem_type(mem_type),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] mt);
    int nz;
    nz = (mt == 2'd0) ? 3 : (mt == 2'd3) ? 5 : 4;
    return (a >> nz) << nz;
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic w, input logic ns,
                                           input logic p, input logic [4:0] id);
    return (32'(w) << 24) | (32'(ns) << 21) | (32'(p) << 20) | 32'(id);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic access(input logic [4:0] id, input logic [31:0] a, input logic w,
                        input logic ns, input logic p, input logic rf, input logic [1:0] mt);
    acc_valid = 1; acc_id = id; acc_addr = a; acc_write = w;
    acc_ns = ns; acc_priv = p; acc_region_fail = rf; mem_type = mt;
    @(negedge clk);
    acc_valid = 0; acc_region_fail = 0;
  endtask

  task automatic expect_rec(input string req, input logic [31:0] ea, input logic [31:0] ec);
    logic [31:0] d;
    rd(8'h20, d); check(req, d, ea);
    rd(8'h28, d); check(req, d, ec);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 reset irq", 32'(irq), 32'd0);
    rd(8'h00, d); check("R1 reset cfg", d, 32'd0);
    expect_rec("R5 R6 reset record", 32'd0, 32'd0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(8'h00, 32'h8000_0004);
    rd(8'h00, d); check("R1 cfg readback", d, 32'h8000_0004);
  endtask

  task automatic t_region_fail;
    logic [31:0] d;
    access(5'd3, 32'h1234_5677, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0);
    check("R3 irq set", 32'(irq), 32'd1);
    rd(8'h2C, d); check("R7 irq readback", d, 32'd1);
    expect_rec("R5 R6 region fail", exp_addr(32'h1234_5677, 2'd0), exp_ctrl(1, 1, 0, 3));
  endtask

  task automatic t_hold;
    access(5'd9, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
    check("R3 irq sticky", 32'(irq), 32'd1);
    expect_rec("R4 record held", exp_addr(32'h1234_5677, 2'd0), exp_ctrl(1, 1, 0, 3));
  endtask

  task automatic t_clear;
    wr(8'h2C, 32'h0000_0000);
    check("R7 zero write ignored", 32'(irq), 32'd1);
    wr(8'h2C, 32'h0000_0001);
    check("R7 clear", 32'(irq), 32'd0);
  endtask

  task automatic t_sec_mismatch;
    // master 31 is non-secure in cfg, presents a secure access
    access(5'd31, 32'hABCD_EF1F, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3);
    check("R2 mismatch fails", 32'(irq), 32'd1);
    expect_rec("R2 R5 R6 mismatch record", exp_addr(32'hABCD_EF1F, 2'd3), exp_ctrl(0, 0, 1, 31));
    wr(8'h2C, 32'h1);
  endtask

  task automatic t_no_fail;
    // master 31 non-secure with ns access; master 5 secure with secure access
    access(5'd31, 32'h0000_1111, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1);
    access(5'd5,  32'h0000_2222, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    check("R9 no irq", 32'(irq), 32'd0);
    expect_rec("R9 record untouched", exp_addr(32'hABCD_EF1F, 2'd3), exp_ctrl(0, 0, 1, 31));
  endtask

  task automatic t_same_cycle;
    access(5'd1, 32'h0000_0F0F, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2);
    // clear and failure together
    reg_wr = 1; reg_addr = 8'h2C; reg_wdata = 32'h1;
    acc_valid = 1; acc_id = 5'd17; acc_addr = 32'h5555_55FF; acc_write = 1;
    acc_ns = 0; acc_priv = 1; acc_region_fail = 1; mem_type = 2'd1;
    @(negedge clk);
    reg_wr = 0; acc_valid = 0; acc_region_fail = 0;
    check("R8 irq stays", 32'(irq), 32'd1);
    expect_rec("R8 new record", exp_addr(32'h5555_55FF, 2'd1), exp_ctrl(1, 0, 1, 17));
    wr(8'h2C, 32'h1);
  endtask

  task automatic t_masks;
    for (int mt = 0; mt < 4; mt++) begin
      access(5'd2, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1, 2'(mt));
      expect_rec("R5 mask per type", exp_addr(32'hFFFF_FFFF, 2'(mt)), exp_ctrl(0, 1, 1, 2));
      wr(8'h2C, 32'h1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_region_fail();
    t_hold();
    t_clear();
    t_sec_mismatch();
    t_no_fail();
    t_same_cycle();
    t_masks();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule